// File: doc/BRIEF.md
# Video capture decimator and address generator

This block sits between a video input port and the frame-buffer write path of a capture engine. It receives a stream of 8-bit or 16-bit pixel units, qualified by a clock enable, together with horizontal and vertical sync inputs. Each sync has a programmable active level. For every unit the block decides whether the unit lands in memory. The unit must fall inside a capture window, which is placed by a row and column offset. It must also survive two 32-bit drop masks: one works per unit along the line and one works per line down the frame.

Each kept unit produces a one-cycle write strobe, carrying a frame-buffer byte address and the unit's data. A frame starts at one of two base addresses, picked by a buffer-select input. The line address then steps by a programmable stride. Optionally, only every other frame is captured. Software pulse inputs can stand in for either sync or reload the line address from the selected base at once. Memory arbitration and colour conversion happen downstream.

Top module: `vcd_capture_top`

## Requirements
- R1: A sync input is active when its level equals its polarity bit (1 = active high, 0 = active low). A hardware sync event is a change from inactive to active, seen between two successive cycles that have pix_en high. No unit is taken on a pix_en cycle in which either sync is active or a sync event occurs.
- R2: A vertical event resets the line index and column index to 0. It also loads the line address with base1 when buf_sel is 1, or with base0 when buf_sel is 0, with the base's three lowest bits treated as 0. No write occurs after reset until the first vertical event.
- R3: The column index C counts taken units from 0 after every sync event. A unit can be written only if off_cols <= C < off_cols + win_cols. Columns sit in the low half of win_ofs and win_size, rows in the high half.
- R4: A unit inside the column window is dropped when bit ((C - off_cols) mod 32) of hmask is set.
- R5: The line index L counts horizontal events since the vertical event. A line is kept only if off_rows <= L < off_rows + win_rows and bit (L mod 32) of vmask is clear. The row offset does not shift this mask index.
- R6: The write address is the line address plus the size of the units already written on that line: 1 byte per unit in byte mode (wide16 = 0) and 2 bytes per unit in word mode. Dropped and out-of-window units do not move it. wr_data is {8'h00, pix_data[7:0]} in byte mode and pix_data in word mode.
- R7: Every horizontal event clears the in-line offset. A horizontal event that ends a kept line adds the stride to the line address, with the stride's two lowest bits treated as 0.
- R8: When skip_first_hs is set, the first horizontal event after a vertical event advances neither L nor the line address.
- R9: Vertical events since reset are numbered 1, 2, 3, and so on. When skip_alt is set, only frames with odd numbers are written.
- R10: A one-cycle pulse on sw_vsync or sw_hsync has the effect of the matching sync event in that cycle, whatever the level of pix_en.
- R11: A pulse on sw_load reloads the line address from the selected base and clears the in-line offset. L and C are left unchanged.
- R12: wr_stb is high for exactly the cycle after the pix_en cycle that carried the kept unit. After reset, wr_stb, wr_addr and wr_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable: inputs are sampled in this cycle |
| pix_data | input | 16 | Pixel unit; only the low byte is used in byte mode |
| hsync_in | input | 1 | Horizontal sync from the video source |
| vsync_in | input | 1 | Vertical sync from the video source |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| wide16 | input | 1 | 1 = 16-bit units, 0 = bytes |
| win_size | input | 32 | Window rows [31:16], columns [15:0] |
| win_ofs | input | 32 | Offset rows [31:16], columns [15:0] |
| hmask | input | 32 | Per-unit drop mask along the line |
| vmask | input | 32 | Per-line drop mask from vertical sync |
| stride | input | 22 | Bytes between kept line starts |
| base0 | input | 22 | Frame base when buf_sel is 0 |
| base1 | input | 22 | Frame base when buf_sel is 1 |
| buf_sel | input | 1 | Base select |
| skip_alt | input | 1 | Capture every other frame |
| skip_first_hs | input | 1 | Ignore the first horizontal event of a frame |
| sw_vsync | input | 1 | Software vertical event pulse |
| sw_hsync | input | 1 | Software horizontal event pulse |
| sw_load | input | 1 | Software base reload pulse |
| wr_stb | output | 1 | Frame-buffer write strobe |
| wr_addr | output | 22 | Frame-buffer byte address |
| wr_data | output | 16 | Write data |

## Verification
The bench checks how the horizontal mask is anchored to the column offset rather than to the line start. A design that gets this wrong drops the wrong units and writes a different count. It also checks that dropped or out-of-window units leave the address untouched; a design that moved it anyway would start each line past its base. On the vertical side it uses a row offset with a masked line inside the window, and a stride with its low bits set. These expose mask indexing that follows the offset, stride added on every line, and stride bits that are not forced to zero. Finally it covers inverted sync polarity, the suppressed first horizontal event, alternate-frame skipping from reset, base selection and software reload. Each of these shows up as missing, extra or misplaced writes.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

   typedef enum logic {
      UNIT_BYTE = 1'b0,
      UNIT_WORD = 1'b1
   } unit_mode_e;

   typedef struct packed {
      logic vert;
      logic horz;
   } sync_pair_t;

   localparam int unsigned BASE_ALIGN_BITS   = 3;
   localparam int unsigned STRIDE_ALIGN_BITS = 2;

endpackage

// File: rtl/vcd_sync_edge.sv
module vcd_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pix_en,
   input  logic raw,
   input  logic pol,
   input  logic sw_pulse,
   output logic active,
   output logic evt
);
   logic act_q;

   assign active = pol ? raw : ~raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= 1'b0;
      else if (pix_en)
         act_q <= active;
   end

   assign evt = sw_pulse | (pix_en & active & ~act_q);

   AST_HW_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !sw_pulse) |-> (pix_en && !act_q)) else $error("hw edge"); // R1

endmodule

// File: rtl/vcd_position.sv
module vcd_position #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_take,
   input  logic              vs_evt,
   input  logic              hs_evt,
   input  logic              skip_first_hs,
   input  logic              skip_alt,
   input  logic [CNT_W-1:0]  off_cols,
   input  logic [CNT_W-1:0]  win_cols,
   input  logic [CNT_W-1:0]  off_rows,
   input  logic [CNT_W-1:0]  win_rows,
   input  logic [MASK_W-1:0] hmask,
   input  logic [MASK_W-1:0] vmask,
   output logic              unit_keep,
   output logic              line_keep,
   output logic              line_adv,
   output logic              frame_ok
);
   localparam int unsigned MB = $clog2(MASK_W);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] col_q, row_q;
   logic             first_h_q, par_q, live_q;
   logic [CNT_W-1:0] col_rel, row_rel;
   logic             col_in, row_in;

   always_comb begin
      col_rel = col_q - off_cols;
      row_rel = row_q - off_rows;
      col_in  = (col_q >= off_cols) && (col_rel < win_cols);
      row_in  = (row_q >= off_rows) && (row_rel < win_rows);
   end

   assign line_adv  = hs_evt && !vs_evt && !(skip_first_hs && first_h_q);
   assign frame_ok  = live_q && (!skip_alt || par_q);
   assign line_keep = row_in && !vmask[row_q[MB-1:0]];
   assign unit_keep = frame_ok && line_keep && col_in && !hmask[col_rel[MB-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q     <= '0;
         row_q     <= '0;
         first_h_q <= 1'b0;
         par_q     <= 1'b0;
         live_q    <= 1'b0;
      end else if (vs_evt) begin
         col_q     <= '0;
         row_q     <= '0;
         first_h_q <= 1'b1;
         par_q     <= ~par_q;
         live_q    <= 1'b1;
      end else if (hs_evt) begin
         col_q     <= '0;
         first_h_q <= 1'b0;
         if (line_adv && row_q != CNT_MAX)
            row_q <= row_q + 1'b1;
      end else if (pix_take && col_q != CNT_MAX) begin
         col_q <= col_q + 1'b1;
      end
   end

   AST_FIRST_HS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_evt && !vs_evt && skip_first_hs && first_h_q) |=> $stable(row_q)) else $error("first hs"); // R8
   AST_VS_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> (row_q == '0 && col_q == '0)) else $error("vs clear"); // R2

endmodule

// File: rtl/vcd_addr.sv
module vcd_addr #(
   parameter int unsigned ADDR_W  = 22,
   parameter bit          WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_evt,
   input  logic              hs_evt,
   input  logic              load_now,
   input  logic              line_adv,
   input  logic              line_keep,
   input  logic              take_keep,
   input  logic              wide16,
   input  logic              buf_sel,
   input  logic [ADDR_W-1:0] base0,
   input  logic [ADDR_W-1:0] base1,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              wide_eff
);
   import vcd_pkg::*;

   localparam logic [ADDR_W-1:0] BASE_MASK   = ~(ADDR_W'((1 << BASE_ALIGN_BITS) - 1));
   localparam logic [ADDR_W-1:0] STRIDE_MASK = ~(ADDR_W'((1 << STRIDE_ALIGN_BITS) - 1));

   logic [ADDR_W-1:0] line_q, ofs_q, base_sel, stride_al, step;
   unit_mode_e        mode;

   generate
      if (WORD_EN) begin : g_word
         assign wide_eff = wide16;
      end else begin : g_byte
         assign wide_eff = 1'b0;
      end
   endgenerate

   assign mode      = wide_eff ? UNIT_WORD : UNIT_BYTE;
   assign step      = (mode == UNIT_WORD) ? ADDR_W'(2) : ADDR_W'(1);
   assign base_sel  = (buf_sel ? base1 : base0) & BASE_MASK;
   assign stride_al = stride & STRIDE_MASK;
   assign cur_addr  = line_q + ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         ofs_q  <= '0;
      end else if (vs_evt || load_now) begin
         line_q <= base_sel;
         ofs_q  <= '0;
      end else if (hs_evt) begin
         ofs_q <= '0;
         if (line_adv && line_keep)
            line_q <= line_q + stride_al;
      end else if (take_keep) begin
         ofs_q <= ofs_q + step;
      end
   end

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      line_q[1:0] == 2'b00) else $error("line align"); // R7
   AST_VS_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> line_q == $past(base_sel)) else $error("base load"); // R2
   AST_OFS_ONLY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_keep && !vs_evt && !hs_evt && !load_now) |=> $stable(ofs_q)) else $error("ofs moved"); // R6

endmodule

// File: rtl/vcd_capture_top.sv
module vcd_capture_top #(
   parameter int unsigned ADDR_W  = 22,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MASK_W  = 32,
   parameter int unsigned DATA_W  = 16,
   parameter bit          WORD_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pix_en,
   input  logic [DATA_W-1:0]    pix_data,
   input  logic                 hsync_in,
   input  logic                 vsync_in,
   input  logic                 hs_pol,
   input  logic                 vs_pol,
   input  logic                 wide16,
   input  logic [2*CNT_W-1:0]   win_size,
   input  logic [2*CNT_W-1:0]   win_ofs,
   input  logic [MASK_W-1:0]    hmask,
   input  logic [MASK_W-1:0]    vmask,
   input  logic [ADDR_W-1:0]    stride,
   input  logic [ADDR_W-1:0]    base0,
   input  logic [ADDR_W-1:0]    base1,
   input  logic                 buf_sel,
   input  logic                 skip_alt,
   input  logic                 skip_first_hs,
   input  logic                 sw_vsync,
   input  logic                 sw_hsync,
   input  logic                 sw_load,
   output logic                 wr_stb,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data
);
   import vcd_pkg::*;

   localparam int unsigned HALF_W = DATA_W / 2;

   generate
      if ((MASK_W & (MASK_W - 1)) != 0 || MASK_W < 2) begin : g_bad_mask
         $error("MASK_W must be a power of two");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W too small for base alignment");
      end
      if (DATA_W != 16) begin : g_bad_data
         $error("DATA_W must be 16");
      end
   endgenerate

   sync_pair_t raw_s, pol_s, sw_s, act_s, evt_s;

   assign raw_s = '{vert: vsync_in, horz: hsync_in};
   assign pol_s = '{vert: vs_pol,   horz: hs_pol};
   assign sw_s  = '{vert: sw_vsync, horz: sw_hsync};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sync
         vcd_sync_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pix_en   (pix_en),
            .raw      (raw_s[g]),
            .pol      (pol_s[g]),
            .sw_pulse (sw_s[g]),
            .active   (act_s[g]),
            .evt      (evt_s[g])
         );
      end
   endgenerate

   logic pix_take, unit_keep, line_keep, line_adv, frame_ok, wide_eff;
   logic [ADDR_W-1:0] cur_addr;

   assign pix_take = pix_en & ~act_s.vert & ~act_s.horz & ~evt_s.vert & ~evt_s.horz;

   vcd_position #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_pos (
      .clk           (clk),
      .rst_n         (rst_n),
      .pix_take      (pix_take),
      .vs_evt        (evt_s.vert),
      .hs_evt        (evt_s.horz),
      .skip_first_hs (skip_first_hs),
      .skip_alt      (skip_alt),
      .off_cols      (win_ofs[CNT_W-1:0]),
      .win_cols      (win_size[CNT_W-1:0]),
      .off_rows      (win_ofs[2*CNT_W-1:CNT_W]),
      .win_rows      (win_size[2*CNT_W-1:CNT_W]),
      .hmask         (hmask),
      .vmask         (vmask),
      .unit_keep     (unit_keep),
      .line_keep     (line_keep),
      .line_adv      (line_adv),
      .frame_ok      (frame_ok)
   );

   vcd_addr #(.ADDR_W(ADDR_W), .WORD_EN(WORD_EN)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .vs_evt    (evt_s.vert),
      .hs_evt    (evt_s.horz),
      .load_now  (sw_load),
      .line_adv  (line_adv),
      .line_keep (line_keep),
      .take_keep (pix_take & unit_keep),
      .wide16    (wide16),
      .buf_sel   (buf_sel),
      .base0     (base0),
      .base1     (base1),
      .stride    (stride),
      .cur_addr  (cur_addr),
      .wide_eff  (wide_eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= pix_take & unit_keep;
         if (pix_take & unit_keep) begin
            wr_addr <= cur_addr;
            wr_data <= wide_eff ? pix_data : {{HALF_W{1'b0}}, pix_data[HALF_W-1:0]};
         end
      end
   end

   AST_STB_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(pix_en)) else $error("stb source"); // R12
   AST_NO_WR_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> !wr_stb) else $error("frame gate"); // R9
   AST_NO_WR_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (act_s.vert || act_s.horz) |=> !wr_stb) else $error("sync write"); // R1

endmodule

// File: tb/sim_vcd_capture_top.sv
module sim_vcd_capture_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0;
   logic [15:0] pix_data = '0;
   logic        hsync_in = 1'b0, vsync_in = 1'b0;
   logic        hs_pol = 1'b1, vs_pol = 1'b1;
   logic        wide16 = 1'b0;
   logic [31:0] win_size = {16'd16, 16'd16};
   logic [31:0] win_ofs = '0;
   logic [31:0] hmask = '0, vmask = '0;
   logic [21:0] stride = 22'h40, base0 = 22'h100, base1 = 22'h2000;
   logic        buf_sel = 1'b0, skip_alt = 1'b0, skip_first_hs = 1'b0;
   logic        sw_vsync = 1'b0, sw_hsync = 1'b0, sw_load = 1'b0;
   logic        wr_stb;
   logic [21:0] wr_addr;
   logic [15:0] wr_data;

   int total = 0, bad = 0;
   int wr_cnt = 0;
   logic [21:0] first_addr, last_addr;
   logic [15:0] last_data;

   always #10 clk = ~clk;

   vcd_capture_top u0 (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_data(pix_data),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .hs_pol(hs_pol), .vs_pol(vs_pol),
      .wide16(wide16), .win_size(win_size), .win_ofs(win_ofs), .hmask(hmask),
      .vmask(vmask), .stride(stride), .base0(base0), .base1(base1),
      .buf_sel(buf_sel), .skip_alt(skip_alt), .skip_first_hs(skip_first_hs),
      .sw_vsync(sw_vsync), .sw_hsync(sw_hsync), .sw_load(sw_load),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         if (wr_cnt == 0) first_addr = wr_addr;
         last_addr = wr_addr;
         last_data = wr_data;
         wr_cnt = wr_cnt + 1;
      end
   end

   typedef struct packed {
      logic [31:0] hm;
      logic [15:0] oc;
      logic [15:0] wc;
      logic        wd;
      logic [7:0]  n;
      logic [21:0] fa;
      logic [21:0] la;
      logic [15:0] ld;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'h0000_0000, 16'd0, 16'd12, 1'b0, 8'd12, 22'h100, 22'h10B, 16'h000B},
      '{32'h0000_0000, 16'd3, 16'd4,  1'b0, 8'd4,  22'h100, 22'h103, 16'h0006},
      '{32'h0000_0005, 16'd2, 16'd8,  1'b0, 8'd6,  22'h100, 22'h105, 16'h0009},
      '{32'hFFFF_FFFF, 16'd0, 16'd12, 1'b0, 8'd0,  22'h000, 22'h000, 16'h0000},
      '{32'h0000_0002, 16'd1, 16'd5,  1'b1, 8'd4,  22'h100, 22'h106, 16'h5A05}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clr();
      wr_cnt = 0;
   endtask

   task automatic pix(input int n, input int start);
      for (int i = 0; i < n; i++) begin
         pix_en = 1'b1;
         pix_data = {8'h5A, 8'(start + i)};
         tick();
      end
      pix_en = 1'b0;
      tick();
      tick();
   endtask

   task automatic sync_pulse(input bit vert);
      if (vert) vsync_in = vs_pol; else hsync_in = hs_pol;
      pix_en = 1'b1;
      tick();
      if (vert) vsync_in = ~vs_pol; else hsync_in = ~hs_pol;
      pix_en = 1'b0;
      tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      #(20 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk("R12 reset stb", 32'(wr_stb), 0);
      chk("R12 reset addr", 32'(wr_addr), 0);
      chk("R12 reset data", 32'(wr_data), 0);
      do_reset();

      // R2: nothing written before the first vertical event
      clr();
      pix(4, 0);
      chk("R2 no frame yet", wr_cnt, 0);

      // R3 R4 R6: vector table, one line per entry
      for (int v = 0; v < 5; v++) begin
         hmask    = VECS[v].hm;
         win_ofs  = {16'd0, VECS[v].oc};
         win_size = {16'd16, VECS[v].wc};
         wide16   = VECS[v].wd;
         sync_pulse(1'b1);
         clr();
         pix(12, 0);
         chk($sformatf("R3 R4 count vec%0d", v), wr_cnt, 32'(VECS[v].n));
         if (VECS[v].n != 0) begin
            chk($sformatf("R6 first addr vec%0d", v), 32'(first_addr), 32'(VECS[v].fa));
            chk($sformatf("R6 last addr vec%0d", v), 32'(last_addr), 32'(VECS[v].la));
            chk($sformatf("R6 last data vec%0d", v), 32'(last_data), 32'(VECS[v].ld));
         end
      end
      hmask = '0; wide16 = 1'b0; win_ofs = '0; win_size = {16'd16, 16'd16};

      // R1: active-low vertical sync
      vs_pol = 1'b0; vsync_in = 1'b1;
      tick();
      sync_pulse(1'b1);
      clr();
      pix(3, 0);
      chk("R1 low vsync count", wr_cnt, 3);
      chk("R1 low vsync addr", 32'(first_addr), 32'h100);
      // R1: active-low horizontal sync moves to line 1, outside a 1-row window
      win_size = {16'd1, 16'd16};
      hs_pol = 1'b0; hsync_in = 1'b1;
      tick();
      sync_pulse(1'b0);
      clr();
      pix(3, 0);
      chk("R1 low hsync line", wr_cnt, 0);
      vs_pol = 1'b1; vsync_in = 1'b0; hs_pol = 1'b1; hsync_in = 1'b0;
      tick();

      // R5 R7: row window 1..3, line 1 masked, stride low bits ignored
      win_ofs = {16'd1, 16'd0}; win_size = {16'd3, 16'd16};
      vmask = 32'h2; stride = 22'h43;
      sync_pulse(1'b1);
      for (int ln = 0; ln < 5; ln++) begin
         clr();
         pix(2, 0);
         chk($sformatf("R5 line%0d count", ln), wr_cnt, (ln == 2 || ln == 3) ? 2 : 0);
         if (ln == 2) chk("R7 line2 addr", 32'(first_addr), 32'h100);
         if (ln == 3) chk("R7 line3 addr", 32'(first_addr), 32'h140);
         sync_pulse(1'b0);
      end
      win_ofs = '0; vmask = '0; stride = 22'h40;

      // R8: first horizontal event suppressed
      win_size = {16'd1, 16'd16};
      skip_first_hs = 1'b1;
      sync_pulse(1'b1);
      sync_pulse(1'b0);
      clr();
      pix(2, 0);
      chk("R8 suppressed count", wr_cnt, 2);
      chk("R8 suppressed addr", 32'(first_addr), 32'h100);
      skip_first_hs = 1'b0;
      sync_pulse(1'b1);
      sync_pulse(1'b0);
      clr();
      pix(2, 0);
      chk("R8 normal count", wr_cnt, 0);
      win_size = {16'd16, 16'd16};

      // R9: alternate frames from reset
      do_reset();
      skip_alt = 1'b1;
      for (int f = 1; f <= 3; f++) begin
         sync_pulse(1'b1);
         clr();
         pix(2, 0);
         chk($sformatf("R9 frame%0d", f), wr_cnt, (f % 2 == 1) ? 2 : 0);
      end
      skip_alt = 1'b0;

      // R10 R2: software vertical event with base1 (low bits ignored)
      buf_sel = 1'b1; base1 = 22'h2007;
      sw_vsync = 1'b1;
      tick();
      sw_vsync = 1'b0;
      tick();
      clr();
      pix(3, 0);
      chk("R10 sw vsync count", wr_cnt, 3);
      chk("R2 base1 addr", 32'(first_addr), 32'h2000);

      // R11: reload from base0 mid-line
      buf_sel = 1'b0;
      sw_load = 1'b1;
      tick();
      sw_load = 1'b0;
      // R12: strobe exactly one cycle after the sample
      pix_en = 1'b1; pix_data = 16'h5A33;
      tick();
      chk("R12 stb high", 32'(wr_stb), 1);
      chk("R11 reload addr", 32'(wr_addr), 32'h100);
      pix_en = 1'b0;
      tick();
      chk("R12 stb low", 32'(wr_stb), 0);

      // R10: software horizontal event leaves a 1-row window
      win_size = {16'd1, 16'd16};
      sw_hsync = 1'b1;
      tick();
      sw_hsync = 1'b0;
      tick();
      clr();
      pix(2, 0);
      chk("R10 sw hsync count", wr_cnt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule